// File: doc/BRIEF.md
# Dual-Criterion All-Ones Alarm Detector

This block watches a 2.048 Mbit/s framed serial stream, one bit per cycle where a strobe is high, and raises an alarm when the line carries an all-ones alarm indication signal. It decides this by counting zeros over fixed windows of strobed bits. The counter stops at three, because only "two or fewer" and "three or more" matter. A mode input picks one of two criteria. Mode 0 is the long criterion: a window of `LONG_BITS` strobes, 512000 by default, which is 250 ms at line rate. It is qualified by a frame-alignment-lost level. Mode 1 is the double-frame criterion: consecutive windows of `DF_BITS` strobes (512), with matching rules for setting and clearing.

A frame-alignment-found pulse clears the alarm at once in mode 1. A simulation control forces the alarm on. Any rising edge of the alarm sets a sticky interrupt flag that stays set until reset. Window boundaries run freely from strobe counters. When the mode input changes, both windows and the double-frame history start over. Frame alignment search is done elsewhere.

Top module: `ais_detect`

## Requirements
- R1: After reset, `ais_alarm` and `ais_irq` are low. The stored mode resets to 0, so a mode of 1 in the first cycle after reset counts as a mode change (R9).
- R2: Only cycles with `bit_vld` high advance the windows. A window ends on its `DF_BITS`-th (mode 1) or `LONG_BITS`-th (mode 0) strobed bit. A zero offered while `bit_vld` is low is not counted.
- R3: In mode 1 (`mode`=1), the alarm goes high in the cycle after a window ends with two or fewer zeros, provided the window before it also had two or fewer zeros.
- R4: In mode 1, the alarm goes low in the cycle after a window ends with three or more zeros, provided the window before it also had three or more zeros.
- R5: In mode 1, the alarm holds its value in three cases: when a window ends and the previous window fell on the other side of the threshold, when no previous window exists since reset or since a mode change, and at every cycle in between window ends.
- R6: In mode 1, an `align_found` pulse drives the alarm low in the next cycle. It wins over a set in the same cycle. In mode 0 it has no effect.
- R7: In mode 0 (`mode`=0), the alarm goes high in the cycle after a long window ends with two or fewer zeros, if `align_lost` is high on that window's last strobed bit.
- R8: In mode 0, the alarm goes low in the cycle after a long window ends without meeting the R7 condition. It does not change inside a window.
- R9: Any change of `mode` restarts both windows, discards the bit of that cycle, and forgets the previous double-frame window.
- R10: While `sim_force` is high, the alarm is high from the next cycle on. One cycle after `sim_force` falls, the alarm shows the state of the real detection.
- R11: `ais_irq` goes high in the same cycle as every rising edge of `ais_alarm` and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Received data bit |
| bit_vld | input | 1 | Strobe marking `bit_in` as a line bit |
| mode | input | 1 | 0 = long criterion, 1 = double-frame criterion |
| align_lost | input | 1 | High while frame alignment is lost |
| align_found | input | 1 | One-cycle pulse when frame alignment is found |
| sim_force | input | 1 | Forces the alarm on |
| ais_alarm | output | 1 | Alarm level |
| ais_irq | output | 1 | Sticky flag set by a rising alarm |

## Verification
The bench builds the block with `LONG_BITS`=64 and `DF_BITS`=16, so a full long window takes only a few dozen strobes. At that size the double-frame rules can be swept over every ordered pair of zero counts from 0 to 4, with idle strobe-low cycles carrying zeros mixed into each window. The short windows also put mid-window holds, mode-change restarts, found-pulse priority and release of the simulation control within a few hundred cycles. Each of these is checked against expectations the bench derives from the zero counts it sends.

// File: rtl/ais_pkg.sv
package ais_pkg;

    typedef enum logic {
        MODE_LONG   = 1'b0,
        MODE_DFRAME = 1'b1
    } ais_mode_e;

    localparam int ZBITS = 2;
    localparam logic [ZBITS-1:0] ZMAX   = 2'd3;
    localparam logic [ZBITS-1:0] ZLIMIT = 2'd2;

    typedef logic [ZBITS-1:0] zcnt_t;

    // saturating increment of the zero tally
    function automatic zcnt_t zsat_inc(zcnt_t z, logic inc);
        if (inc && (z != ZMAX)) begin
            return z + 2'd1;
        end
        return z;
    endfunction

    typedef struct packed {
        logic      real_al;
        logic      alarm;
        logic      prev_low;
        logic      prev_valid;
        ais_mode_e mode_q;
    } top_state_t;

endpackage

// File: rtl/ais_window.sv
module ais_window
    import ais_pkg::*;
#(
    parameter int LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    input  logic zero,
    output logic done,
    output logic low
);

    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        zcnt_t         zeros;
    } win_t;

    win_t  win_d, win_q;
    zcnt_t zeros_now;
    logic  at_last;

    always_comb begin
        win_d     = win_q;
        zeros_now = zsat_inc(win_q.zeros, step & zero);
        at_last   = step && (win_q.cnt == LAST);
        done      = at_last && !restart;
        low       = (zeros_now <= ZLIMIT);
        if (restart) begin
            win_d.cnt   = '0;
            win_d.zeros = '0;
        end else if (step) begin
            if (at_last) begin
                win_d.cnt   = '0;
                win_d.zeros = '0;
            end else begin
                win_d.cnt   = win_q.cnt + 1'b1;
                win_d.zeros = zeros_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

endmodule

// File: rtl/ais_edge_flag.sv
module ais_edge_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_d,
    input  logic lvl_q,
    output logic flag
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q | (lvl_d & ~lvl_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/ais_detect.sv
module ais_detect
    import ais_pkg::*;
#(
    parameter int LONG_BITS = 512000,
    parameter int DF_BITS   = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    input  logic mode,
    input  logic align_lost,
    input  logic align_found,
    input  logic sim_force,
    output logic ais_alarm,
    output logic ais_irq
);

    localparam int NWIN = 2;
    localparam int LEN_OF [NWIN] = '{LONG_BITS, DF_BITS};

    top_state_t st_d, st_q;
    ais_mode_e  mode_e;
    logic       restart;
    logic [NWIN-1:0] win_done;
    logic [NWIN-1:0] win_low;

    assign mode_e  = ais_mode_e'(mode);
    assign restart = (mode_e != st_q.mode_q);

    // index 0: long window, index 1: double-frame window
    for (genvar w = 0; w < NWIN; w++) begin : g_win
        ais_window #(.LEN(LEN_OF[w])) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .step    (bit_vld),
            .zero    (~bit_in),
            .done    (win_done[w]),
            .low     (win_low[w])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.mode_q = mode_e;
        if (restart) begin
            st_d.prev_valid = 1'b0;
            st_d.prev_low   = 1'b0;
        end else if (mode_e == MODE_LONG) begin
            if (win_done[0]) begin
                st_d.real_al = win_low[0] & align_lost;
            end
        end else begin
            if (win_done[1]) begin
                if (st_q.prev_valid) begin
                    if (win_low[1] && st_q.prev_low) begin
                        st_d.real_al = 1'b1;
                    end else if (!win_low[1] && !st_q.prev_low) begin
                        st_d.real_al = 1'b0;
                    end
                end
                st_d.prev_low   = win_low[1];
                st_d.prev_valid = 1'b1;
            end
        end
        if ((mode_e == MODE_DFRAME) && align_found) begin
            st_d.real_al = 1'b0;
        end
        st_d.alarm = sim_force | st_d.real_al;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{real_al: 1'b0, alarm: 1'b0, prev_low: 1'b0,
                      prev_valid: 1'b0, mode_q: MODE_LONG};
        end else begin
            st_q <= st_d;
        end
    end

    ais_edge_flag u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_d (st_d.alarm),
        .lvl_q (st_q.alarm),
        .flag  (ais_irq)
    );

    assign ais_alarm = st_q.alarm;

endmodule

// File: rtl/ais_detect_chk.sv
module ais_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_vld,
    input logic mode,
    input logic align_lost,
    input logic align_found,
    input logic sim_force,
    input logic ais_alarm,
    input logic ais_irq
);

    // R1
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!ais_alarm && !ais_irq));

    // R11
    p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ais_irq |=> ais_irq);

    // R11
    p_irq_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ais_alarm) |-> ais_irq);

    // R10
    p_sim_forces_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sim_force |=> ais_alarm);

    // R6
    p_found_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (align_found && mode && !sim_force) |=> !ais_alarm);

    // R2
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !align_found && !sim_force && !$past(sim_force))
        |=> $stable(ais_alarm));

    // R7
    p_long_needs_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ais_alarm) && !$past(sim_force) && !$past(mode))
        |-> $past(align_lost));

endmodule

bind ais_detect ais_detect_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_vld     (bit_vld),
    .mode        (mode),
    .align_lost  (align_lost),
    .align_found (align_found),
    .sim_force   (sim_force),
    .ais_alarm   (ais_alarm),
    .ais_irq     (ais_irq)
);

// File: tb/sim_ais_detect.sv
module sim_ais_detect;

    localparam int LB = 64;
    localparam int DB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b1;
    logic bit_vld = 1'b0;
    logic mode = 1'b1;
    logic align_lost = 1'b0;
    logic align_found = 1'b0;
    logic sim_force = 1'b0;
    logic ais_alarm;
    logic ais_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ais_detect #(.LONG_BITS(LB), .DF_BITS(DB)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_in      (bit_in),
        .bit_vld     (bit_vld),
        .mode        (mode),
        .align_lost  (align_lost),
        .align_found (align_found),
        .sim_force   (sim_force),
        .ais_alarm   (ais_alarm),
        .ais_irq     (ais_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic m);
        mode = m; rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b1;
        align_lost = 1'b0; align_found = 1'b0; sim_force = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic b);
        bit_in = b; bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic idle();
        bit_in = 1'b0; bit_vld = 1'b0;
        @(negedge clk);
        bit_in = 1'b1;
    endtask

    // window of len strobed bits, k zeros, idle zero cycles interleaved
    task automatic send_window(input int len, input int k, input int upto);
        for (int i = 0; i < upto; i++) begin
            send((i < k) ? 1'b0 : 1'b1);
            if (i % 5 == 4) idle();
        end
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic exp;
        int   pk;
        bit   have_prev;

        // R1 reset state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 alarm after reset", ais_alarm, 1'b0);
        check("R1 irq after reset", ais_irq, 1'b0);

        // R2 R3 R4 R5 sweep over ordered pairs of zero counts, mode 1
        do_reset(1'b1);
        exp = 1'b0; have_prev = 1'b0; pk = 0;
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                for (int s = 0; s < 2; s++) begin
                    int k;
                    k = (s == 0) ? a : b;
                    send_window(DB, k, DB);
                    if (have_prev) begin
                        if (pk <= 2 && k <= 2) exp = 1'b1;
                        else if (pk >= 3 && k >= 3) exp = 1'b0;
                    end
                    check("R3/R4/R5 (R2 strobe gating) double-frame", ais_alarm, exp);
                    pk = k; have_prev = 1'b1;
                end
            end
        end
        check("R11 irq after sweep", ais_irq, 1'b1);

        // R5 mid-window hold and R6 found pulse in mode 1
        send_window(DB, 0, DB);
        send_window(DB, 0, DB);
        check("R3 set before found", ais_alarm, 1'b1);
        send_window(DB, 4, 7);
        check("R5 hold mid-window", ais_alarm, 1'b1);
        align_found = 1'b1; @(negedge clk); align_found = 1'b0;
        check("R6 found clears mode 1", ais_alarm, 1'b0);
        check("R11 irq stays after fall", ais_irq, 1'b1);

        // R9 mode change restarts windows and history
        do_reset(1'b1);
        send_window(DB, 0, DB);
        check("R5 no history first window", ais_alarm, 1'b0);
        send_window(DB, 0, 8);
        mode = 1'b0; @(negedge clk);
        mode = 1'b1; @(negedge clk);
        send_window(DB, 0, DB);
        check("R9 history forgotten", ais_alarm, 1'b0);
        send_window(DB, 0, DB - 1);
        check("R9 boundary moved", ais_alarm, 1'b0);
        send(1'b1);
        check("R9 set after restarted pair", ais_alarm, 1'b1);

        // R7 R8 mode 0 long window
        do_reset(1'b0);
        align_lost = 1'b1;
        send_window(LB, 2, LB - 1);
        check("R8 no change inside long window", ais_alarm, 1'b0);
        send(1'b1);
        check("R7 long set with 2 zeros", ais_alarm, 1'b1);
        check("R11 irq on long set", ais_irq, 1'b1);
        align_found = 1'b1; @(negedge clk); align_found = 1'b0;
        check("R6 found ignored mode 0", ais_alarm, 1'b1);
        send_window(LB, 3, LB);
        check("R8 long clear with 3 zeros", ais_alarm, 1'b0);
        align_lost = 1'b0;
        send_window(LB, 0, LB);
        check("R7 no set while aligned", ais_alarm, 1'b0);
        align_lost = 1'b1;
        send_window(LB, 0, LB);
        check("R7 set all ones lost", ais_alarm, 1'b1);
        send_window(LB, 1, LB - 1);
        align_lost = 1'b0;
        send(1'b1);
        check("R8 clear when alignment returns", ais_alarm, 1'b0);

        // R10 simulation control
        do_reset(1'b1);
        sim_force = 1'b1; @(negedge clk);
        check("R10 sim forces alarm", ais_alarm, 1'b1);
        check("R11 irq from sim", ais_irq, 1'b1);
        sim_force = 1'b0; @(negedge clk);
        check("R10 release without condition", ais_alarm, 1'b0);
        check("R11 irq sticky after sim", ais_irq, 1'b1);
        send_window(DB, 1, DB);
        send_window(DB, 2, DB);
        check("R3 real set before sim", ais_alarm, 1'b1);
        sim_force = 1'b1; @(negedge clk);
        sim_force = 1'b0; @(negedge clk);
        check("R10 release keeps real alarm", ais_alarm, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule